// File: doc/BRIEF.md
# PCI configuration address translator

This block sits on the host side of a PCI root and turns accesses to a configuration window pair into standard configuration cycles. Software first stores a 32-bit selector word in an index window, then reads or writes the data window. For every data-window access the block builds a bus/device/function/register address from the stored selector and the low bits of the access offset, and issues it, together with the access size and write data, as one request on a valid/ready port toward a configuration space model. A read returns to the host only when that model answers.

The selector word has three layouts. When its top bit is set it is forwarded nearly as it stands. When its lowest bit is set it already holds a type-1 style address and only its byte-lane bits are replaced. Otherwise it is a type-0 style word in which the device is named by a one-hot select line in the upper bits; the block priority-encodes that field into a device number and packs device, function and register into the usual layout.

Top module: `cfg_window_xlate`

## Requirements
- R1: After reset the stored selector is zero, `hst_done` is low and `cfg_req_valid` is low; a selector read right after reset returns zero.
- R2: A host access with `hst_sel_data`=0 targets the selector: a write stores all 32 bits of `hst_wdata` regardless of `hst_size`, a read returns the stored word, and `hst_done` is high for exactly one cycle, the cycle after the access is accepted.
- R3: If selector bit 31 is 1, `cfg_addr` equals the selector OR'ed with data-window offset bits 1:0.
- R4: If selector bit 31 is 0 and bit 0 is 1, `cfg_addr` equals the selector with bits 2:0 replaced by data-window offset bits 2:0.
- R5: If selector bits 31 and 0 are both 0, `cfg_addr` bits 31:16 are 0, bits 15:11 hold the position (11 to 31) of the lowest set selector bit among bits 31:11, bits 10:8 hold selector bits 10:8, bits 7:3 hold selector bits 7:3 and bits 2:0 hold offset bits 2:0.
- R6: In the R5 layout, when none of selector bits 31:11 is set, `cfg_addr` bits 15:11 are all ones (device 31).
- R7: `cfg_size` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), `cfg_write` and `cfg_wdata` repeat the host access unchanged for reads and writes; data-window offset bits above bit 2 have no effect on `cfg_addr`.
- R8: A data-window read ends with `hst_done` high in the cycle after `cfg_rsp_valid`, with `hst_rdata` equal to the `cfg_rdata` of that response.
- R9: A data-window write ends with `hst_done` high in the cycle after the request is accepted (`cfg_req_valid` and `cfg_req_ready` both high); no response is awaited.
- R10: The request is raised the cycle after the host access is accepted and, while `cfg_req_ready` is low, `cfg_req_valid`, `cfg_addr`, `cfg_size`, `cfg_write` and `cfg_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_valid | input | 1 | Host access present; held until `hst_done` |
| hst_sel_data | input | 1 | 0 = selector window, 1 = data window |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_offset | input | OFS_W | Byte offset inside the 4 KiB window |
| hst_size | input | 2 | Access size code: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| hst_wdata | input | 32 | Host write data, little-endian |
| hst_done | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 32 | Read result, valid with `hst_done` |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Configuration request accepted |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_size | output | 2 | Access size code passed through |
| cfg_write | output | 1 | Write flag passed through |
| cfg_wdata | output | 32 | Write data passed through |
| cfg_rsp_valid | input | 1 | Read response valid |
| cfg_rdata | input | 32 | Read response data |

## Verification
A selector access completes one cycle after acceptance, the configuration request appears one cycle after a data access is accepted, a write completes one cycle after the request handshake and a read one cycle after the response pulse. The bench drives every input on the falling edge and samples on the falling edge at exactly those points, holding `cfg_req_ready` low for a random number of cycles to confirm that the request stays put. Expected addresses come from a bench function that scans the selector upward for the device bit, while the design scans downward.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned SIZE_W = 2;
   localparam int unsigned LANE_W = 3;
   localparam int unsigned DEV_W  = 5;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RSP  = 2'd2,
      ST_DONE = 2'd3
   } cfgx_state_t;
endpackage

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg
   import cfgx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_val,
   output logic [WORD_W-1:0] sel_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_word <= '0;
      else if (load)
         sel_word <= load_val;
   end

   assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> sel_word == $past(load_val));
endmodule

// File: rtl/cfgx_addr_xlate.sv
module cfgx_addr_xlate
   import cfgx_pkg::*;
#(
   parameter int unsigned SLOT_LSB = 11
) (
   input  logic [WORD_W-1:0] sel_word,
   input  logic [LANE_W-1:0] lane,
   output logic [WORD_W-1:0] addr
);
   localparam int unsigned FUNC_LSB = 8;

   generate
      if (SLOT_LSB < FUNC_LSB + 3 || SLOT_LSB >= WORD_W) begin : g_bad_slot
         $error("cfgx_addr_xlate: SLOT_LSB out of range");
      end
   endgenerate

   logic [DEV_W-1:0] dev_num;

   // downward scan: the last hit is the lowest set select bit
   always_comb begin
      dev_num = '1;
      for (int b = WORD_W - 1; b >= int'(SLOT_LSB); b--) begin
         if (sel_word[b])
            dev_num = DEV_W'(b);
      end
   end

   always_comb begin
      if (sel_word[WORD_W-1])
         addr = sel_word | {{(WORD_W-2){1'b0}}, lane[1:0]};
      else if (sel_word[0])
         addr = {sel_word[WORD_W-1:LANE_W], lane};
      else
         addr = {16'h0000, dev_num, sel_word[FUNC_LSB+2:FUNC_LSB],
                 sel_word[FUNC_LSB-1:LANE_W], lane};
   end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
   import cfgx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_valid,
   input  logic              hst_sel_data,
   input  logic              hst_write,
   input  logic [LANE_W-1:0] hst_lane,
   input  logic [SIZE_W-1:0] hst_size,
   input  logic [WORD_W-1:0] hst_wdata,
   input  logic [WORD_W-1:0] sel_word,
   output logic              sel_load,
   output logic [LANE_W-1:0] lane_q,
   output logic              hst_done,
   output logic [WORD_W-1:0] hst_rdata,
   output logic              cfg_req_valid,
   input  logic              cfg_req_ready,
   output logic [SIZE_W-1:0] cfg_size,
   output logic              cfg_write,
   output logic [WORD_W-1:0] cfg_wdata,
   input  logic              cfg_rsp_valid,
   input  logic [WORD_W-1:0] cfg_rdata
);
   cfgx_state_t state;

   assign sel_load      = (state == ST_IDLE) && hst_valid && !hst_sel_data && hst_write;
   assign cfg_req_valid = (state == ST_REQ);
   assign hst_done      = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lane_q    <= '0;
         cfg_size  <= '0;
         cfg_write <= 1'b0;
         cfg_wdata <= '0;
         hst_rdata <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (hst_valid) begin
               if (hst_sel_data) begin
                  lane_q    <= hst_lane;
                  cfg_size  <= hst_size;
                  cfg_write <= hst_write;
                  cfg_wdata <= hst_wdata;
                  state     <= ST_REQ;
               end else begin
                  if (!hst_write)
                     hst_rdata <= sel_word;
                  state <= ST_DONE;
               end
            end
            ST_REQ: if (cfg_req_ready)
               state <= cfg_write ? ST_DONE : ST_RSP;
            ST_RSP: if (cfg_rsp_valid) begin
               hst_rdata <= cfg_rdata;
               state     <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_valid && !cfg_req_ready) |=>
         cfg_req_valid && $stable(cfg_size) && $stable(cfg_write) && $stable(cfg_wdata));

   assert_rd_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RSP && cfg_rsp_valid) |=> hst_done && hst_rdata == $past(cfg_rdata));

   assert_wr_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_valid && cfg_req_ready && cfg_write) |=> hst_done);

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hst_done |=> !hst_done);

   assert_req_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && hst_valid && hst_sel_data) |=> cfg_req_valid);
endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate
   import cfgx_pkg::*;
#(
   parameter int unsigned OFS_W    = 12,
   parameter int unsigned SLOT_LSB = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_valid,
   input  logic              hst_sel_data,
   input  logic              hst_write,
   input  logic [OFS_W-1:0]  hst_offset,
   input  logic [1:0]        hst_size,
   input  logic [31:0]       hst_wdata,
   output logic              hst_done,
   output logic [31:0]       hst_rdata,
   output logic              cfg_req_valid,
   input  logic              cfg_req_ready,
   output logic [31:0]       cfg_addr,
   output logic [1:0]        cfg_size,
   output logic              cfg_write,
   output logic [31:0]       cfg_wdata,
   input  logic              cfg_rsp_valid,
   input  logic [31:0]       cfg_rdata
);
   generate
      if (OFS_W < LANE_W || OFS_W > 16) begin : g_bad_ofs
         $error("cfg_window_xlate: OFS_W must lie in 3..16");
      end
   endgenerate

   logic [WORD_W-1:0] sel_word;
   logic              sel_load;
   logic [LANE_W-1:0] lane_q;
   logic              unused_ofs_hi;

   // window offset bits above the byte lane do not reach the address
   assign unused_ofs_hi = ^hst_offset;

   cfgx_index_reg u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sel_load),
      .load_val (hst_wdata),
      .sel_word (sel_word)
   );

   cfgx_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .hst_valid     (hst_valid),
      .hst_sel_data  (hst_sel_data),
      .hst_write     (hst_write),
      .hst_lane      (hst_offset[LANE_W-1:0]),
      .hst_size      (hst_size),
      .hst_wdata     (hst_wdata),
      .sel_word      (sel_word),
      .sel_load      (sel_load),
      .lane_q        (lane_q),
      .hst_done      (hst_done),
      .hst_rdata     (hst_rdata),
      .cfg_req_valid (cfg_req_valid),
      .cfg_req_ready (cfg_req_ready),
      .cfg_size      (cfg_size),
      .cfg_write     (cfg_write),
      .cfg_wdata     (cfg_wdata),
      .cfg_rsp_valid (cfg_rsp_valid),
      .cfg_rdata     (cfg_rdata)
   );

   cfgx_addr_xlate #(.SLOT_LSB(SLOT_LSB)) u_xlate (
      .sel_word (sel_word),
      .lane     (lane_q),
      .addr     (cfg_addr)
   );

   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_valid && !cfg_req_ready) |=> $stable(cfg_addr));

   assert_fmt_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_valid && sel_word[31]) |-> cfg_addr[31:2] == sel_word[31:2]);

   assert_fmt_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_valid && !sel_word[31] && sel_word[0]) |-> cfg_addr[31:3] == sel_word[31:3]);

   assert_fmt_t0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_valid && !sel_word[31] && !sel_word[0]) |->
         cfg_addr[31:16] == 16'h0000 && cfg_addr[10:3] == sel_word[10:3]);

   assert_no_dev_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_valid && sel_word[31:11] == 21'h0 && !sel_word[0]) |-> cfg_addr[15:11] == 5'h1f);
endmodule

// File: tb/cfg_window_xlate_test.sv
module cfg_window_xlate_test;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_valid = 1'b0, hst_sel_data = 1'b0, hst_write = 1'b0;
   logic [11:0] hst_offset = '0;
   logic [1:0]  hst_size = '0;
   logic [31:0] hst_wdata = '0;
   logic        hst_done;
   logic [31:0] hst_rdata;
   logic        cfg_req_valid;
   logic        cfg_req_ready = 1'b0;
   logic [31:0] cfg_addr;
   logic [1:0]  cfg_size;
   logic        cfg_write;
   logic [31:0] cfg_wdata;
   logic        cfg_rsp_valid = 1'b0;
   logic [31:0] cfg_rdata = '0;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   logic [31:0] model_sel = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_window_xlate uut (
      .clk(clk), .rst_n(rst_n),
      .hst_valid(hst_valid), .hst_sel_data(hst_sel_data), .hst_write(hst_write),
      .hst_offset(hst_offset), .hst_size(hst_size), .hst_wdata(hst_wdata),
      .hst_done(hst_done), .hst_rdata(hst_rdata),
      .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
      .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_write(cfg_write),
      .cfg_wdata(cfg_wdata), .cfg_rsp_valid(cfg_rsp_valid), .cfg_rdata(cfg_rdata)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_LIMIT) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: cycle limit reached, actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // upward scan for the device select bit, independent of the design's form
   function automatic logic [31:0] exp_addr(input logic [31:0] s, input logic [11:0] o);
      int dev;
      if (s[31]) return s | {30'h0, o[1:0]};
      if (s[0])  return {s[31:3], o[2:0]};
      dev = 31;
      for (int b = 11; b < 32; b++) begin
         if (s[b]) begin
            dev = b;
            break;
         end
      end
      return {16'h0, dev[4:0], s[10:8], s[7:3], o[2:0]};
   endfunction

   task automatic sel_access(input bit wr, input logic [31:0] wd, input logic [1:0] sz);
      @(negedge clk);
      hst_valid = 1'b1; hst_sel_data = 1'b0; hst_write = wr;
      hst_wdata = wd; hst_size = sz; hst_offset = 12'($urandom);
      @(negedge clk);
      chk(hst_done == 1'b1, "R2", "selector done", 32'(hst_done), 32'd1);
      if (wr) model_sel = wd;
      else chk(hst_rdata == model_sel, "R2", "selector readback", hst_rdata, model_sel);
      hst_valid = 1'b0;
      @(negedge clk);
      chk(hst_done == 1'b0, "R2", "done single pulse", 32'(hst_done), 32'd0);
   endtask

   task automatic data_access(input bit wr, input logic [11:0] ofs, input logic [1:0] sz,
                              input logic [31:0] wd, input int stall, input string req);
      logic [31:0] ea;
      logic [31:0] rsp;
      ea = exp_addr(model_sel, ofs);
      @(negedge clk);
      hst_valid = 1'b1; hst_sel_data = 1'b1; hst_write = wr;
      hst_offset = ofs; hst_size = sz; hst_wdata = wd;
      @(negedge clk);
      chk(cfg_req_valid == 1'b1, "R10", "request raised", 32'(cfg_req_valid), 32'd1);
      chk(cfg_addr == ea, req, "translated address", cfg_addr, ea);
      chk(cfg_size == sz && cfg_write == wr, "R7", "size/write pass",
          {29'h0, cfg_write, cfg_size}, {29'h0, wr, sz});
      if (wr) chk(cfg_wdata == wd, "R7", "write data pass", cfg_wdata, wd);
      for (int i = 0; i < stall; i++) begin
         @(negedge clk);
         chk(cfg_req_valid == 1'b1 && cfg_addr == ea && hst_done == 1'b0, "R10",
             "held during stall", cfg_addr, ea);
      end
      cfg_req_ready = 1'b1;
      @(negedge clk);
      cfg_req_ready = 1'b0;
      if (wr) begin
         chk(hst_done == 1'b1, "R9", "write done after accept", 32'(hst_done), 32'd1);
      end else begin
         chk(hst_done == 1'b0 && cfg_req_valid == 1'b0, "R8", "read waits for response",
             {30'h0, hst_done, cfg_req_valid}, 32'd0);
         rsp = $urandom;
         cfg_rsp_valid = 1'b1; cfg_rdata = rsp;
         @(negedge clk);
         cfg_rsp_valid = 1'b0; cfg_rdata = $urandom;
         chk(hst_done == 1'b1, "R8", "read done after response", 32'(hst_done), 32'd1);
         chk(hst_rdata == rsp, "R8", "read data", hst_rdata, rsp);
      end
      hst_valid = 1'b0;
      @(negedge clk);
      chk(hst_done == 1'b0, "R2", "done single pulse", 32'(hst_done), 32'd0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(hst_done == 1'b0 && cfg_req_valid == 1'b0, "R1", "outputs in reset",
          {30'h0, hst_done, cfg_req_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hst_done == 1'b0 && cfg_req_valid == 1'b0, "R1", "outputs after reset",
          {30'h0, hst_done, cfg_req_valid}, 32'd0);
      sel_access(1'b0, 32'h0, 2'd2);   // R1 readback of zero

      // R3 raw form
      sel_access(1'b1, 32'h8000_1234, 2'd2);
      data_access(1'b0, 12'hFF6, 2'd0, 32'h0, 0, "R3");
      // R4 type-1 form, high offset bits ignored (R7)
      sel_access(1'b1, 32'h0012_3459, 2'd0);
      data_access(1'b1, 12'hFFD, 2'd1, 32'hCAFE_F00D, 2, "R4");
      sel_access(1'b0, 32'h0, 2'd2);
      // R5 type-0: lowest select bit wins
      sel_access(1'b1, 32'h0010_0B48, 2'd2);
      data_access(1'b0, 12'h003, 2'd2, 32'h0, 1, "R5");
      sel_access(1'b1, 32'h4000_0000 | 32'h0000_05F8, 2'd2);
      data_access(1'b1, 12'h807, 2'd2, 32'h1357_9BDF, 0, "R5");
      // R6 no select bit
      sel_access(1'b1, 32'h0000_07FC, 2'd2);
      data_access(1'b0, 12'h002, 2'd1, 32'h0, 3, "R6");
      // R3 with select bits also set
      sel_access(1'b1, 32'hC000_0801, 2'd2);
      data_access(1'b1, 12'h00B, 2'd0, 32'h0000_00A5, 0, "R3");

      for (int n = 0; n < 200; n++) begin
         int kind;
         logic [31:0] s;
         string rq;
         kind = $urandom_range(0, 4);
         s = $urandom;
         case (kind)
            0: begin s[31] = 1'b1; rq = "R3"; end
            1: begin s[31] = 1'b0; s[0] = 1'b1; rq = "R4"; end
            2: begin s[31:11] = 21'h0; s[0] = 1'b0; rq = "R6"; end
            3: begin s[31:11] = 21'h1 << $urandom_range(0, 19); s[0] = 1'b0; rq = "R5"; end
            default: begin s[31] = 1'b0; s[0] = 1'b0; rq = "R5"; end
         endcase
         if (s[31:11] == 21'h0 && kind != 0 && kind != 1) rq = "R6";
         sel_access(1'b1, s, 2'($urandom_range(0, 2)));
         if ($urandom_range(0, 3) == 0) sel_access(1'b0, 32'h0, 2'd2);
         data_access(1'($urandom), 12'($urandom), 2'($urandom_range(0, 2)),
                     $urandom, $urandom_range(0, 3), rq);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule